// File: doc/BRIEF.md
# Power Button Debounce and Override

This block watches an active-low power button, removes contact bounce, and turns each press into one event pulse. The raw button line idles high through a pull-up. It is first synchronized to the clock and then filtered, so that only a level that stays steady for a set number of cycles counts as a press or a release.

The block marks the cycle in which a filtered press begins. If the system is running, it raises a one-cycle request to enter sleep. If the system is already asleep, it raises a one-cycle wake pulse instead. When the button stays down long enough, a separate one-cycle override pulse asks for a forced soft-off, whatever the sleep state is. Only one override is issued per hold.

A power-management state machine outside the block consumes the pulses. The filter window and the hold threshold are parameters counted in clock cycles. The default values are small, for simulation; a real build scales them to tens of milliseconds and several seconds.

Top module: `pwrbtn_ctrl`

## Requirements
- R1: While reset is held and right after it, the button counts as released, and `sleep_req_o`, `wake_o` and `override_o` are all low.
- R2: The filtered button level changes only after the synchronized input has differed from it for DEB_CYCLES consecutive cycles. A low glitch shorter than that produces no pulse.
- R3: At a filtered press edge with `sleeping_i` = 0, `sleep_req_o` is high for exactly one cycle.
- R4: At a filtered press edge with `sleeping_i` = 1, `wake_o` is high for exactly one cycle.
- R5: If the filtered press lasts HOLD_CYCLES cycles, `override_o` pulses for one cycle, exactly HOLD_CYCLES cycles after the press-edge pulse. This holds for either value of `sleeping_i`.
- R6: A hold yields at most one override pulse. No further pulse of any kind comes until the filtered level returns to released.
- R7: At most one output is high in any cycle. The earlier sleep or wake pulse of a press is never withdrawn. Changing `sleeping_i` during a hold produces no pulse.
- R8: A release of the button, with or without bounce, produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_ni | input | 1 | Raw power button, low when pressed |
| sleeping_i | input | 1 | System is in a sleep state |
| sleep_req_o | output | 1 | One-cycle request to enter sleep |
| wake_o | output | 1 | One-cycle wake event |
| override_o | output | 1 | One-cycle forced soft-off request |

## Verification
The assertions check on every cycle that the three outputs are mutually exclusive and that each pulse lasts one cycle. They also check that the filtered level moves only when its counter reaches the limit, and that an override pulse is raised only while the button is held. The bench scenarios are needed to show the rest. Those scenarios cover:
- glitch and bounce rejection;
- the choice between sleep request and wake, made from the sleep flag;
- the exact distance from the press pulse to the override;
- a single override during a very long hold;
- no pulse on release.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;
  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_SLEEP    = 2'd1,
    EV_WAKE     = 2'd2,
    EV_OVERRIDE = 2'd3
  } pwrbtn_ev_e;
endpackage

// File: rtl/pwrbtn_sync.sv
module pwrbtn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= 1'b1;  // idle high
        else if (i == 0) stage_q[i] <= d_i;
        else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwrbtn_debounce.sv
module pwrbtn_debounce #(
  parameter int unsigned DEB_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_sync_i,
  output logic pressed_o,
  output logic press_edge_o
);
  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(DEB_CYCLES - 1);

  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b1;
      cnt_q  <= '0;
      edge_q <= 1'b0;
    end else begin
      edge_q <= 1'b0;
      if (btn_sync_i == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LIM) begin
        lvl_q  <= btn_sync_i;
        cnt_q  <= '0;
        edge_q <= ~btn_sync_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pressed_o    = ~lvl_q;
  assign press_edge_o = edge_q;

  assert_level_after_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> ($past(cnt_q) == LIM && $past(btn_sync_i) == lvl_q));
endmodule

// File: rtl/pwrbtn_hold.sv
module pwrbtn_hold #(
  parameter int unsigned HOLD_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pressed_i,
  output logic override_o
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HLIM = HW'(HOLD_CYCLES - 1);

  logic [HW-1:0] hcnt_q;
  logic          fired_q;
  logic          ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q  <= '0;
      fired_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      ovr_q <= 1'b0;
      if (!pressed_i) begin
        hcnt_q  <= '0;
        fired_q <= 1'b0;
      end else if (!fired_q) begin
        if (hcnt_q == HLIM) begin
          ovr_q   <= 1'b1;
          fired_q <= 1'b1;
        end else begin
          hcnt_q <= hcnt_q + 1'b1;
        end
      end
    end
  end

  assign override_o = ovr_q;

  assert_override_only_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    override_o |-> $past(pressed_i));
  assert_single_override_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    override_o |=> !override_o);
endmodule

// File: rtl/pwrbtn_ctrl.sv
module pwrbtn_ctrl
  import pwrbtn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 8,
  parameter int unsigned HOLD_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  input  logic sleeping_i,
  output logic sleep_req_o,
  output logic wake_o,
  output logic override_o
);
  logic btn_sync, pressed, press_edge, ovr;
  pwrbtn_ev_e ev;

  pwrbtn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(btn_ni), .q_o(btn_sync));

  pwrbtn_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .btn_sync_i(btn_sync),
    .pressed_o(pressed), .press_edge_o(press_edge));

  pwrbtn_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .pressed_i(pressed), .override_o(ovr));

  always_comb begin
    ev = EV_NONE;
    if (ovr)             ev = EV_OVERRIDE;
    else if (press_edge) ev = sleeping_i ? EV_WAKE : EV_SLEEP;
  end

  assign sleep_req_o = (ev == EV_SLEEP);
  assign wake_o      = (ev == EV_WAKE);
  assign override_o  = (ev == EV_OVERRIDE);

  assert_outputs_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sleep_req_o, wake_o, override_o}));
  assert_sleep_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_o |=> !sleep_req_o);
  assert_wake_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !(sleep_req_o || wake_o || override_o));
endmodule

// File: tb/sim_pwrbtn_ctrl.sv
module sim_pwrbtn_ctrl;
  localparam int DEB  = 8;
  localparam int HOLD = 64;
  localparam int K_SLEEP = 1, K_WAKE = 2, K_OVR = 3;

  logic clk = 1'b0, rst_n = 1'b0, btn_n = 1'b1, sleeping = 1'b0;
  logic sleep_req, wake, ovr;
  int checks = 0, errors = 0, cyc = 0, pulses = 0, last_press_cyc = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwrbtn_ctrl #(.SYNC_STAGES(2), .DEB_CYCLES(DEB), .HOLD_CYCLES(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .btn_ni(btn_n), .sleeping_i(sleeping),
    .sleep_req_o(sleep_req), .wake_o(wake), .override_o(ovr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // drive a press of n cycles; push expected events
  task automatic press(input int n, input bit slp);
    sleeping = slp;
    exp_q.push_back(slp ? K_WAKE : K_SLEEP);
    if (n >= HOLD + 10) exp_q.push_back(K_OVR);
    btn_n = 1'b0;
    step(n);
    btn_n = 1'b1;
    step(DEB + 20);
    chk(exp_q.size() == 0, "R8 no pulse pending after release", exp_q.size(), 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int k;
      k = 0;
      if (sleep_req + wake + ovr > 1) chk(1'b0, "R7 outputs exclusive", sleep_req + wake + ovr, 1);
      if (sleep_req) k = K_SLEEP;
      else if (wake) k = K_WAKE;
      else if (ovr) k = K_OVR;
      if (k != 0) begin
        pulses++;
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected pulse", k, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(k == e, (e == K_OVR) ? "R5 event kind" : "R3 R4 event kind", k, e);
          if (k == K_OVR)
            chk(cyc - last_press_cyc == HOLD, "R5 override distance", cyc - last_press_cyc, HOLD);
        end
        if (k != K_OVR) last_press_cyc = cyc;
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    step(3);
    chk({sleep_req, wake, ovr} == 3'b000, "R1 outputs in reset", {sleep_req, wake, ovr}, 0);
    rst_n = 1'b1;
    step(DEB + 10);
    chk({sleep_req, wake, ovr} == 3'b000 && pulses == 0, "R1 quiet after reset", pulses, 0);

    // R3: short press awake
    press(30, 1'b0);
    // R4: short press asleep
    press(30, 1'b1);

    // R2: glitch shorter than window
    p0 = pulses;
    btn_n = 1'b0; step(DEB - 3); btn_n = 1'b1; step(DEB + 20);
    chk(pulses == p0, "R2 glitch ignored", pulses - p0, 0);

    // R2 R8: bouncy press and bouncy release give one pulse
    sleeping = 1'b0;
    exp_q.push_back(K_SLEEP);
    for (int b = 0; b < 4; b++) begin
      btn_n = 1'b0; step(3); btn_n = 1'b1; step(2);
    end
    btn_n = 1'b0; step(30);
    for (int b = 0; b < 4; b++) begin
      btn_n = 1'b1; step(2); btn_n = 1'b0; step(3);
    end
    btn_n = 1'b1; step(DEB + 20);
    chk(exp_q.size() == 0, "R2 bounce gives one pulse", exp_q.size(), 0);

    // R5: long press awake and asleep
    press(HOLD + 30, 1'b0);
    press(HOLD + 30, 1'b1);
    // R6: very long hold, one override only
    p0 = pulses;
    press(4 * HOLD, 1'b0);
    chk(pulses - p0 == 2, "R6 one override per hold", pulses - p0, 2);

    // R7: sleep flag flips during hold, no new pulse, earlier kept
    p0 = pulses;
    sleeping = 1'b0;
    exp_q.push_back(K_SLEEP);
    exp_q.push_back(K_OVR);
    btn_n = 1'b0; step(DEB + 15);
    sleeping = 1'b1; step(20);
    sleeping = 1'b0; step(HOLD);
    btn_n = 1'b1; step(DEB + 20);
    chk(pulses - p0 == 2 && exp_q.size() == 0, "R7 flag change ignored", pulses - p0, 2);

    // R8: idle stretch stays silent
    p0 = pulses;
    step(200);
    chk(pulses == p0, "R8 idle silent", pulses - p0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule